// File: doc/BRIEF.md
# Reloading Countdown Timer Bank

This block holds a small set of countdown timers that run side by side without sharing any state. Each timer has a counter that counts down to zero and then reloads itself from a programmed value, so it fires at a fixed period. When a timer fires it can latch an interrupt request, emit a one-cycle trigger pulse for a downstream converter sequencer, or do both. Software drives the bank through a write-only port. Through that port it sets load values and per-channel controls, and it clears latched requests.

The last channel is the wake-up timer. It counts on a separate slow clock derived from the crystal and keeps running while the system is in stop mode. Its load value and run bit cross into that clock domain through a holding register and a toggle handshake. Its zero events come back as single-cycle pulses in the system domain. A zero reached during stop mode raises a wake request, which tells the clock controller to restart the system clock. The other channels freeze while stop mode is asserted.

Top module: `tmr_bank`

## Requirements
- R1: Address map. wr_addr[2:1] selects the channel (0 to 3). wr_addr[0]=0 writes the load value. wr_addr[0]=1 writes control, with bit0 run, bit1 interrupt enable, bit2 trigger enable, and bit3 clear-flag (write 1 to clear). A write to one channel leaves every other channel untouched.
- R2: A system channel that is started with load value L fires every L+1 system cycles. The first trigger appears L+1 cycles after the clock edge that sampled the start write.
- R3: Writing a load value restarts the count from the new value at once. The next event follows L+1 cycles later.
- R4: Clearing run freezes the counter, and no event occurs while it is frozen. Setting run again from 0 restarts the count from the load value.
- R5: The interrupt output is a sticky flag. It is set when a zero is reached with interrupt enable on, and it is cleared by a control write with bit3 set. If a set and a clear fall in the same cycle, the set wins.
- R6: The trigger output is high for exactly one cycle per zero event, and only while trigger enable is on. An interrupt-only channel never pulses its trigger.
- R7: While stop_mode is high, channels 0 to 2 hold their count. When stop_mode falls they continue from the held value, so the next event is delayed by exactly the number of stopped cycles.
- R8: Channel 3 counts on clk_xtal with a period of L+1 crystal cycles and keeps counting during stop_mode. Each of its events reaches irq[3] and trig[3] as a one-cycle pulse in the system domain.
- R9: wake_req, in the crystal domain, goes high when channel 3 reaches zero while stop_mode is high. It returns low once stop_mode has been low for a few crystal cycles.
- R10: After reset, all channels are stopped and irq, trig and wake_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| clk_xtal | input | 1 | Crystal-derived clock for the wake-up channel |
| rst_xtal | input | 1 | Synchronous active-high reset, crystal domain |
| stop_mode | input | 1 | System stop mode indicator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Channel and register select |
| wr_data | input | 32 | Write data |
| irq | output | 4 | Per-channel sticky interrupt flags |
| trig | output | 4 | Per-channel one-cycle trigger pulses |
| wake_req | output | 1 | Wake-up request, crystal domain |

## Verification
Two actions can land in the same cycle: the zero event that sets a channel's interrupt flag, and a software write that clears that flag. The bench counts cycles from the start write so that the clear write is sampled on exactly the edge where the counter wraps. It then expects the flag and the trigger to be high together, with the flag still set. A later clear write with no zero event in that cycle must bring the flag back to 0.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // control word bit positions
  localparam int CTL_RUN = 0;
  localparam int CTL_IRQ = 1;
  localparam int CTL_TRG = 2;
  localparam int CTL_CLR = 3;
  localparam int CTL_W   = 4;
  // synchronizer depth before edge detection
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/tmr_evt.sv
`timescale 1ns/1ps
// Per-channel event stage: sticky interrupt flag and trigger pulse.
module tmr_evt
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ct_we,
  input  logic [CTL_W-1:0] ctl,
  input  logic             zero,
  output logic             irq,
  output logic             trig
);
  logic ie, te;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      te   <= 1'b0;
      irq  <= 1'b0;
      trig <= 1'b0;
    end else begin
      if (ct_we) begin
        ie <= ctl[CTL_IRQ];
        te <= ctl[CTL_TRG];
      end
      trig <= zero & te;
      if (zero & ie)
        irq <= 1'b1;
      else if (ct_we & ctl[CTL_CLR])
        irq <= 1'b0;
    end
  end

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
    (zero && ie) |=> irq);
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq && !ct_we) |=> irq);
  assert_trig_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !(zero && te) |=> !trig);
endmodule

// File: rtl/tmr_sys_chan.sv
`timescale 1ns/1ps
// Down counter with auto reload on the system clock; frozen in stop mode.
module tmr_sys_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic             ld_we,
  input  logic             ct_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             zero
);
  logic             run;
  logic [CNT_W-1:0] load_q, cnt;
  logic             restart;

  assign restart = ld_we | (ct_we & wdata[CTL_RUN] & ~run);
  assign zero    = run & ~stop & ~restart & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      load_q <= '0;
      cnt    <= '0;
    end else begin
      if (ct_we) run <= wdata[CTL_RUN];
      if (ld_we) load_q <= wdata;
      if (ld_we)
        cnt <= wdata;
      else if (restart)
        cnt <= load_q;
      else if (run && !stop) begin
        if (cnt == '0) cnt <= load_q;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !stop && !restart && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_load_restart_R3: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> (cnt == $past(wdata)));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(cnt));
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && !restart) |=> $stable(cnt));
endmodule

// File: rtl/tmr_xtal_chan.sv
`timescale 1ns/1ps
// Wake-up channel: counts on the crystal clock, ignores stop mode,
// hands its zero events back to the system domain as pulses.
module tmr_xtal_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_s,
  input  logic             rst_s,
  input  logic             clk_x,
  input  logic             rst_x,
  input  logic             stop,
  input  logic             ld_we,
  input  logic             ct_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             zero_s,
  output logic             wake_req
);
  // ---------------- system domain ----------------
  logic             run_s, ld_tgl;
  logic [CNT_W-1:0] ld_hold;
  logic [SYNC_N:0]  z_sync;
  logic             z_tgl;

  always_ff @(posedge clk_s) begin
    if (rst_s) begin
      run_s   <= 1'b0;
      ld_tgl  <= 1'b0;
      ld_hold <= '0;
      z_sync  <= '0;
    end else begin
      if (ct_we) run_s <= wdata[CTL_RUN];
      if (ld_we) begin
        ld_hold <= wdata;
        ld_tgl  <= ~ld_tgl;
      end
      z_sync <= {z_sync[SYNC_N-1:0], z_tgl};
    end
  end

  assign zero_s = z_sync[SYNC_N] ^ z_sync[SYNC_N-1];

  // ---------------- crystal domain ----------------
  logic [SYNC_N:0]   ld_sync;
  logic [SYNC_N-1:0] en_sync, st_sync;
  logic              en_d;
  logic [CNT_W-1:0]  load_x, cnt;
  logic              ld_evt, en_rise, restart_x, zero_x, en_x, stop_x;

  assign en_x      = en_sync[SYNC_N-1];
  assign stop_x    = st_sync[SYNC_N-1];
  assign ld_evt    = ld_sync[SYNC_N] ^ ld_sync[SYNC_N-1];
  assign en_rise   = en_x & ~en_d;
  assign restart_x = ld_evt | en_rise;
  assign zero_x    = en_x & ~restart_x & (cnt == '0);

  always_ff @(posedge clk_x) begin
    if (rst_x) begin
      ld_sync  <= '0;
      en_sync  <= '0;
      st_sync  <= '0;
      en_d     <= 1'b0;
      load_x   <= '0;
      cnt      <= '0;
      z_tgl    <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      ld_sync <= {ld_sync[SYNC_N-1:0], ld_tgl};
      en_sync <= {en_sync[SYNC_N-2:0], run_s};
      st_sync <= {st_sync[SYNC_N-2:0], stop};
      en_d    <= en_x;
      if (ld_evt) load_x <= ld_hold;
      if (ld_evt)
        cnt <= ld_hold;
      else if (en_rise)
        cnt <= load_x;
      else if (en_x) begin
        if (cnt == '0) cnt <= load_x;
        else           cnt <= cnt - 1'b1;
      end
      if (zero_x) z_tgl <= ~z_tgl;
      if (!stop_x)
        wake_req <= 1'b0;
      else if (zero_x)
        wake_req <= 1'b1;
    end
  end

  assert_xtal_reload_R8: assert property (@(posedge clk_x) disable iff (rst_x)
    zero_x |=> (cnt == $past(load_x)));
  assert_xtal_down_R8: assert property (@(posedge clk_x) disable iff (rst_x)
    (en_x && !restart_x && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_wake_drop_R9: assert property (@(posedge clk_x) disable iff (rst_x)
    !stop_x |=> !wake_req);
  assert_wake_set_R9: assert property (@(posedge clk_x) disable iff (rst_x)
    (stop_x && zero_x) |=> wake_req);
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
// Bank of reloading countdown timers; the last channel is the wake-up timer.
module tmr_bank
  import tmr_pkg::*;
#(
  parameter  int CNT_W = 32,
  parameter  int N_SYS = 3,
  localparam int N_CH  = N_SYS + 1,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW    = CH_W + 1
) (
  input  logic             clk_sys,
  input  logic             rst_sys,
  input  logic             clk_xtal,
  input  logic             rst_xtal,
  input  logic             stop_mode,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [N_CH-1:0]  irq,
  output logic [N_CH-1:0]  trig,
  output logic             wake_req
);
  logic [N_CH-1:0] ld_we, ct_we, zero;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      ld_we[i] = wr_en && (wr_addr[AW-1:1] == CH_W'(i)) && !wr_addr[0];
      ct_we[i] = wr_en && (wr_addr[AW-1:1] == CH_W'(i)) &&  wr_addr[0];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    if (g < N_SYS) begin : g_sys
      tmr_sys_chan #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk_sys),
        .rst   (rst_sys),
        .stop  (stop_mode),
        .ld_we (ld_we[g]),
        .ct_we (ct_we[g]),
        .wdata (wr_data),
        .zero  (zero[g])
      );
    end else begin : g_wake
      tmr_xtal_chan #(.CNT_W(CNT_W)) u_cnt (
        .clk_s    (clk_sys),
        .rst_s    (rst_sys),
        .clk_x    (clk_xtal),
        .rst_x    (rst_xtal),
        .stop     (stop_mode),
        .ld_we    (ld_we[g]),
        .ct_we    (ct_we[g]),
        .wdata    (wr_data),
        .zero_s   (zero[g]),
        .wake_req (wake_req)
      );
    end

    tmr_evt u_evt (
      .clk   (clk_sys),
      .rst   (rst_sys),
      .ct_we (ct_we[g]),
      .ctl   (wr_data[CTL_W-1:0]),
      .zero  (zero[g]),
      .irq   (irq[g]),
      .trig  (trig[g])
    );
  end

  // R1: at most one register strobe per write
  assert_one_target_R1: assert property (@(posedge clk_sys) disable iff (rst_sys)
    $onehot0({ld_we, ct_we}));
endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  localparam int T_SYS  = 10;
  localparam int T_XTAL = 37;

  logic        clk_sys = 1'b0, clk_xtal = 1'b0;
  logic        rst_sys = 1'b1, rst_xtal = 1'b1;
  logic        stop_mode = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  irq, trig;
  logic        wake_req;

  int total = 0, bad = 0;
  bit done = 0;

  always #(T_SYS/2)  clk_sys  = ~clk_sys;
  always #(T_XTAL/2.0) clk_xtal = ~clk_xtal;

  tmr_bank uut (
    .clk_sys(clk_sys), .rst_sys(rst_sys), .clk_xtal(clk_xtal), .rst_xtal(rst_xtal),
    .stop_mode(stop_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .trig(trig), .wake_req(wake_req)
  );

  function automatic int a_load(input int ch); return ch * 2;     endfunction
  function automatic int a_ctl (input int ch); return ch * 2 + 1; endfunction
  function automatic int period(input int l);  return l + 1;      endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_sys);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk_sys);
    wr_en = 1'b0;
  endtask

  // negedges until trig[ch] is seen high
  task automatic meas(input int ch, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk_sys);
      n++;
    end while (!trig[ch] && n < lim);
  endtask

  initial begin
    #(T_SYS * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, seen;
    void'($urandom(32'd4177));
    repeat (6) @(negedge clk_xtal);
    @(negedge clk_sys); rst_sys = 1'b0; rst_xtal = 1'b0;
    repeat (4) @(negedge clk_xtal);
    @(negedge clk_sys);
    // R10 reset state
    chk(irq == 4'd0, "R10 irq", irq, 0);
    chk(trig == 4'd0, "R10 trig", trig, 0);
    chk(wake_req == 1'b0, "R10 wake", wake_req, 0);

    // R2 random periods on system channels
    for (int k = 0; k < 6; k++) begin
      int ch, l;
      ch = $urandom % 3;
      l  = $urandom % 31;
      wr(a_ctl(ch), 4);
      wr(a_load(ch), l);
      wr(a_ctl(ch), 5);
      meas(ch, 100, n); chk(n == period(l), "R2 first", n, period(l));
      meas(ch, 100, n); chk(n == period(l), "R2 period", n, period(l));
      wr(a_ctl(ch), 4);
    end
    repeat (3) @(negedge clk_sys);

    // R1 independence: ch0 runs, ch1/ch2 stay quiet
    wr(a_load(0), 6); wr(a_ctl(0), 5);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_sys); if (trig[2:1] != 0) seen++; end
    chk(seen == 0, "R1 other channels idle", seen, 0);
    // R3 load write while running
    wr(a_load(0), 3);
    meas(0, 100, n); chk(n == 4, "R3 after load", n, 4);
    meas(0, 100, n); chk(n == 4, "R3 period", n, 4);
    // R4 freeze and restart
    wr(a_ctl(0), 4);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_sys); if (trig[0]) seen++; end
    chk(seen == 0, "R4 frozen", seen, 0);
    wr(a_load(0), 7);
    wr(a_ctl(0), 5);
    meas(0, 100, n); chk(n == 8, "R4 restart", n, 8);

    // R7 stop mode delays by exactly the stopped cycles
    wr(a_load(0), 10);
    repeat (2) @(negedge clk_sys);
    stop_mode = 1'b1;
    seen = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk_sys); if (trig[0]) seen++; end
    stop_mode = 1'b0;
    chk(seen == 0, "R7 no event in stop", seen, 0);
    meas(0, 100, n); chk(n == 9, "R7 resume", n, 9);
    wr(a_ctl(0), 4);

    // R6 interrupt-only channel never triggers
    wr(a_load(1), 4); wr(a_ctl(1), 3);
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk_sys); if (trig[1]) seen++; end
    chk(seen == 0, "R6 no trigger", seen, 0);
    chk(irq[1] == 1'b1, "R6 irq set", irq[1], 1);
    wr(a_ctl(1), 8);
    chk(irq[1] == 1'b0, "R5 w1c", irq[1], 0);

    // R5 set and clear in the same cycle: set wins
    wr(a_load(2), 6); wr(a_ctl(2), 7);
    repeat (5) @(negedge clk_sys);
    wr(a_ctl(2), 15);
    chk(trig[2] == 1'b1, "R6 trig at collision", trig[2], 1);
    chk(irq[2] == 1'b1, "R5 set beats clear", irq[2], 1);
    wr(a_ctl(2), 15);
    chk(irq[2] == 1'b0, "R5 later clear", irq[2], 0);
    @(negedge clk_sys);
    chk(trig[2] == 1'b0, "R6 one cycle", trig[2], 0);
    wr(a_ctl(2), 8);

    // R8 wake-up channel period in system cycles (9+1)*37/10 = 37 +-1
    wr(a_load(3), 9); wr(a_ctl(3), 7);
    meas(3, 400, n);
    meas(3, 400, n); chk(n >= 36 && n <= 38, "R8 period", n, 37);
    chk(wake_req == 1'b0, "R9 no wake outside stop", wake_req, 0);
    stop_mode = 1'b1;
    meas(3, 400, n);
    meas(3, 400, n); chk(n >= 36 && n <= 38, "R8 runs in stop", n, 37);
    chk(irq[3] == 1'b1, "R8 irq", irq[3], 1);
    chk(wake_req == 1'b1, "R9 wake in stop", wake_req, 1);
    stop_mode = 1'b0;
    repeat (20) @(negedge clk_sys);
    chk(wake_req == 1'b0, "R9 wake drops", wake_req, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule